// File: doc/BRIEF.md
# DDR ADC Lane Deinterleaver

This block rebuilds 16-bit converter samples that arrive on 8 single-ended lanes next to a source-synchronous data clock. In every data-clock period each lane carries two neighbouring bits of one sample. The higher bit of the pair is valid at the rising edge and the lower bit is valid at the falling edge. The block captures each lane on both edges and puts every bit into its place in the word. It then flips the most significant bit, which turns the converter's offset-binary code into two's complement.

Finished words go into an 8-entry dual-clock FIFO in the data-clock domain. They are read out in the system clock domain, which runs at the same or a slightly higher rate. Each read is shown for one cycle on a registered output with a valid flag. If a word is ready while the FIFO is full, that word is dropped and a sticky overflow flag is set in the data-clock domain. Only a data-domain reset clears the flag.

Top module: `ddr_lane_rebuild`

## Requirements
- R1: The bit that lane n carries at the rising edge of `dclk` appears at bit 2n+1 of the output word (before the sign conversion in R3).
- R2: The bit that lane n carries at the falling edge appears at bit 2n of the same word. It is paired with the rising-edge bit that came just before it, in the same clock period.
- R3: Bit 15 of every output word is the inverse of the received bit 15, and bits 14..0 are passed through unchanged. For example, offset code 0x0000 comes out as 0x8000, 0x8000 as 0x0000, and 0xFFFF as 0x7FFF.
- R4: When the system clock is at least as fast as the data clock, every sample comes out once, in the order it arrived, with nothing lost and nothing duplicated.
- R5: `out_valid` is high for exactly one `sclk` cycle per delivered sample, and `out_data` carries that sample in the same cycle.
- R6: `overflow` goes high when a finished sample finds the FIFO full. It then stays high while `drst` is low, and it never rises while the FIFO still has room.
- R7: While `drst` is held, `overflow` is low. While `srst` is held, `out_valid` is low.
- R8: The first sample delivered after `drst` is released is the data period that begins at the first rising edge of `dclk` with `drst` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Source-synchronous data clock from the converter |
| drst | input | 1 | Synchronous active-high reset, data-clock domain |
| lanes | input | 8 | Single-ended data lanes, two bits per lane per period |
| sclk | input | 1 | System clock |
| srst | input | 1 | Synchronous active-high reset, system domain |
| out_data | output | 16 | Rebuilt sample in two's complement |
| out_valid | output | 1 | High for one sclk cycle per sample |
| overflow | output | 1 | Sticky flag, data-clock domain: a sample was dropped |

## Verification
The bench sends distinct bit patterns (alternating bits, all zeros, all ones, a lone MSB) and then a stepped ramp. A design that swaps edge halves or places lane n at bits n and n+8 gives scrambled words. A design that skips or misplaces the MSB flip gives values off by 0x8000. The first word after reset is a unique marker, so a design that pairs a falling-edge bit with the wrong rising edge gives a shifted or mixed first word. The system clock runs faster than the data clock, so the FIFO empties now and then. A wrong empty test or a stretched valid would show up as a duplicated or missing ramp entry. The system clock is then halted until the FIFO overflows, to check that the flag sets, holds after the clock restarts, and clears only on a data-domain reset.

// File: rtl/ddr_rebuild_pkg.sv
package ddr_rebuild_pkg;
  localparam int unsigned DEF_LANES       = 8;
  localparam int unsigned DEF_ADDR_BITS   = 3;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic logic [DEF_LANES*2-1:0] offset_to_twos(input logic [DEF_LANES*2-1:0] v);
    logic [DEF_LANES*2-1:0] r;
    r = v;
    r[DEF_LANES*2-1] = ~v[DEF_LANES*2-1];
    return r;
  endfunction
endpackage

// File: rtl/ddr_edge_capture.sv
module ddr_edge_capture #(
  parameter int unsigned LANES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lanes,
  output logic [LANES-1:0] rise_q,
  output logic [LANES-1:0] fall_q,
  output logic             pair_ok
);
  // rising-edge half of the pair
  always_ff @(posedge clk) begin
    rise_q <= lanes;
  end

  // falling-edge half; read at the next rising edge together with rise_q
  always_ff @(negedge clk) begin
    fall_q <= lanes;
  end

  // goes high once the rising half of a full period has been taken after reset
  always_ff @(posedge clk) begin
    if (rst) pair_ok <= 1'b0;
    else     pair_ok <= 1'b1;
  end
endmodule

// File: rtl/ddr_word_assemble.sv
module ddr_word_assemble #(
  parameter int unsigned LANES = 8,
  localparam int unsigned W    = LANES * 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] rise_q,
  input  logic [LANES-1:0] fall_q,
  input  logic             pair_ok,
  output logic [W-1:0]     word,
  output logic             word_valid
);
  logic [W-1:0] placed;

  for (genvar n = 0; n < LANES; n++) begin : g_place
    assign placed[2*n+1] = rise_q[n];
    assign placed[2*n]   = fall_q[n];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word       <= {~placed[W-1], placed[W-2:0]};
      word_valid <= pair_ok;
    end
  end
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/gray_cdc_fifo.sv
module gray_cdc_fifo #(
  parameter int unsigned W           = 16,
  parameter int unsigned ADDR_BITS   = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PW         = ADDR_BITS + 1,
  localparam int unsigned DEPTH      = 1 << ADDR_BITS
) (
  input  logic         wclk,
  input  logic         wrst,
  input  logic         wr_req,
  input  logic [W-1:0] wr_data,
  output logic         wr_full,
  input  logic         rclk,
  input  logic         rrst,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic         rd_pop
);
  localparam logic [PW-1:0] FULL_FLIP = {2'b11, {(PW-2){1'b0}}};

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] wgray_in_r, rgray_in_w;
  logic [PW-1:0] wbin_nx, wgray_nx, rbin_nx, rgray_nx;
  logic          rd_empty;
  logic          wr_push;

  assign wr_push  = wr_req & ~wr_full;
  assign wbin_nx  = wbin + {{(PW-1){1'b0}}, wr_push};
  assign wgray_nx = wbin_nx ^ (wbin_nx >> 1);

  always_ff @(posedge wclk) begin
    if (wr_push) mem[wbin[ADDR_BITS-1:0]] <= wr_data;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin    <= '0;
      wgray   <= '0;
      wr_full <= 1'b0;
    end else begin
      wbin    <= wbin_nx;
      wgray   <= wgray_nx;
      wr_full <= (wgray_nx == (rgray_in_w ^ FULL_FLIP));
    end
  end

  assign rd_pop   = ~rd_empty;
  assign rbin_nx  = rbin + {{(PW-1){1'b0}}, rd_pop};
  assign rgray_nx = rbin_nx ^ (rbin_nx >> 1);

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin     <= '0;
      rgray    <= '0;
      rd_empty <= 1'b1;
      rd_valid <= 1'b0;
    end else begin
      rbin     <= rbin_nx;
      rgray    <= rgray_nx;
      rd_empty <= (rgray_nx == wgray_in_r);
      rd_valid <= rd_pop;
    end
  end

  always_ff @(posedge rclk) begin
    if (rd_pop) rd_data <= mem[rbin[ADDR_BITS-1:0]];
  end

  gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst(rrst), .din(wgray), .dout(wgray_in_r)
  );

  gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst(wrst), .din(rgray), .dout(rgray_in_w)
  );
endmodule

// File: rtl/ddr_lane_rebuild.sv
module ddr_lane_rebuild
  import ddr_rebuild_pkg::*;
#(
  parameter int unsigned LANES       = DEF_LANES,
  parameter int unsigned ADDR_BITS   = DEF_ADDR_BITS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned W          = LANES * 2
) (
  input  logic             dclk,
  input  logic             drst,
  input  logic [LANES-1:0] lanes,
  input  logic             sclk,
  input  logic             srst,
  output logic [W-1:0]     out_data,
  output logic             out_valid,
  output logic             overflow
);
  logic [LANES-1:0] rise_q, fall_q;
  logic             pair_ok;
  logic [W-1:0]     w_word;
  logic             w_valid;
  logic             f_full;
  logic             r_pop;

  ddr_edge_capture #(.LANES(LANES)) u_cap (
    .clk(dclk), .rst(drst), .lanes(lanes),
    .rise_q(rise_q), .fall_q(fall_q), .pair_ok(pair_ok)
  );

  ddr_word_assemble #(.LANES(LANES)) u_asm (
    .clk(dclk), .rst(drst), .rise_q(rise_q), .fall_q(fall_q),
    .pair_ok(pair_ok), .word(w_word), .word_valid(w_valid)
  );

  gray_cdc_fifo #(.W(W), .ADDR_BITS(ADDR_BITS), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
    .wclk(dclk), .wrst(drst), .wr_req(w_valid), .wr_data(w_word), .wr_full(f_full),
    .rclk(sclk), .rrst(srst), .rd_data(out_data), .rd_valid(out_valid), .rd_pop(r_pop)
  );

  always_ff @(posedge dclk) begin
    if (drst)                  overflow <= 1'b0;
    else if (w_valid && f_full) overflow <= 1'b1;
  end
endmodule

// File: rtl/ddr_lane_rebuild_chk.sv
module ddr_lane_rebuild_chk (
  input logic dclk,
  input logic drst,
  input logic sclk,
  input logic srst,
  input logic out_valid,
  input logic overflow,
  input logic w_valid,
  input logic f_full,
  input logic r_pop
);
  AST_OVF_STICKY: assert property (@(posedge dclk) disable iff (drst)
    overflow |=> overflow); // R6

  AST_OVF_CAUSE: assert property (@(posedge dclk) disable iff (drst)
    $rose(overflow) |-> $past(w_valid && f_full)); // R6

  AST_OVF_RESET: assert property (@(posedge dclk)
    drst |=> !overflow); // R7

  AST_OUT_RESET: assert property (@(posedge sclk)
    srst |=> !out_valid); // R7

  AST_VALID_FROM_POP: assert property (@(posedge sclk) disable iff (srst)
    out_valid |-> $past(r_pop)); // R5
endmodule

bind ddr_lane_rebuild ddr_lane_rebuild_chk u_chk (
  .dclk(dclk), .drst(drst), .sclk(sclk), .srst(srst),
  .out_valid(out_valid), .overflow(overflow),
  .w_valid(w_valid), .f_full(f_full), .r_pop(r_pop)
);

// File: tb/ddr_lane_rebuild_bench.sv
module ddr_lane_rebuild_bench;
  localparam int DCLK_PERIOD = 12;
  localparam int SCLK_PERIOD = 10;
  localparam int NL = 8;

  logic          dclk = 1'b0, sclk = 1'b0, sclk_run = 1'b1;
  logic          drst = 1'b1, srst = 1'b1;
  logic [NL-1:0] lanes = '0;
  logic [15:0]   out_data;
  logic          out_valid, overflow;

  int tests = 0, fails = 0, received = 0, sent = 0;
  bit track = 1'b1, reported = 1'b0;
  logic [15:0] expq [$];

  always #(DCLK_PERIOD/2) dclk = ~dclk;
  always begin
    #(SCLK_PERIOD/2);
    if (sclk_run) sclk = ~sclk;
  end

  ddr_lane_rebuild u_ddr_lane_rebuild (
    .dclk(dclk), .drst(drst), .lanes(lanes), .sclk(sclk), .srst(srst),
    .out_data(out_data), .out_valid(out_valid), .overflow(overflow)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // drive one offset-binary code: odd bits before the rising edge, even bits before the falling edge
  task automatic send(input logic [15:0] v);
    for (int n = 0; n < NL; n++) lanes[n] = v[2*n+1];
    if (track) begin
      expq.push_back({~v[15], v[14:0]});
      sent++;
    end
    @(posedge dclk); #1;
    for (int n = 0; n < NL; n++) lanes[n] = v[2*n];
    @(negedge dclk); #1;
  endtask

  // scoreboard monitor
  always @(negedge sclk) begin
    if (out_valid && expq.size() > 0) begin
      logic [15:0] e;
      e = expq.pop_front();
      received++;
      check("R1/R2/R3/R4/R5 sample", out_data, e);
    end
  end

  initial begin
    repeat (150000) @(posedge dclk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    repeat (4) @(posedge dclk);
    #1;
    check("R7 reset out_valid", {15'd0, out_valid}, 16'd0);
    check("R7 reset overflow", {15'd0, overflow}, 16'd0);
    @(negedge sclk); #1 srst = 1'b0;
    @(negedge dclk); #1 drst = 1'b0;
    // R8: first word is a unique marker; R1 R2 via alternating patterns; R3 via boundary codes
    send(16'h1234);
    send(16'hAAAA);
    send(16'h5555);
    send(16'h0000);
    send(16'hFFFF);
    send(16'h8000);
    send(16'h7FFF);
    send(16'h0001);
    send(16'h4000);
    for (int i = 0; i < 48; i++) send(16'(i * 16'h0731 + 16'h0042));
    track = 1'b0;
    for (int i = 0; i < 200 && expq.size() > 0; i++) send(16'h0000);
    check("R4 all samples delivered", 16'(received), 16'(sent));
    check("R6 no overflow in steady flow", {15'd0, overflow}, 16'd0);
    // overflow: stop the reader
    sclk_run = 1'b0;
    for (int i = 0; i < 24; i++) send(16'h0F0F);
    check("R6 overflow sets when full", {15'd0, overflow}, 16'd1);
    sclk_run = 1'b1;
    for (int i = 0; i < 20; i++) send(16'h0F0F);
    check("R6 overflow sticky", {15'd0, overflow}, 16'd1);
    drst = 1'b1;
    repeat (2) @(posedge dclk);
    #1;
    check("R7 drst clears overflow", {15'd0, overflow}, 16'd0);
    report();
  end
endmodule